// File: doc/BRIEF.md
# Service-Level Flit Output Scheduler

This block picks, every cycle, at most one flit to put onto one output link of a five-port wormhole mesh router. Each input port keeps a separate pending-flit slot for each of four service levels. The scheduler looks at every slot's valid, head and tail flags. It finds the most urgent service level that has work and downstream room. Within that level it takes an input port by round-robin. It then raises a one-hot grant toward that slot and forwards the chosen flit's fields.

Service levels are numbered 0 to 3. Level 0 is the most urgent and carries signaling traffic. Level 1 carries real-time streams, level 2 read/write transactions and level 3 bulk block moves. Packets at different levels interleave flit by flit, so an urgent packet can cut into a less urgent packet that is only partly sent. The cut packet continues later from its next flit. Inside a single level a wormhole packet owns that level on this output from its head to its tail. Each level keeps its own credit counter that mirrors free buffer space downstream.

Grant and output fields are combinational from the current inputs and the registered state. The state is the credit counters, the per-level round-robin pointers and the per-level packet locks. It advances on the rising clock edge.

Top module: `flit_out_sched`

## Requirements
- R1: When no service level is eligible, `out_vld` is 0, `grant` is all zero, and no credit, pointer or lock changes at the next edge.
- R2: Of the eligible levels, the one with the lowest number (0 = signaling, 1 = stream, 2 = read/write, 3 = bulk) is sent, whatever the requests at higher-numbered levels.
- R3: A level whose credit counter is 0 is not eligible. In that case a higher-numbered level with credit may send in its place.
- R4: Each level's credit counter resets to DEPTH (default 4). It drops by 1 when a flit of that level is sent and rises by 1 on that level's `credit_ret` bit. When both happen in one cycle the counter keeps its value. `credit_cnt` holds level l in bits [l*3 +: 3].
- R5: Within one level, the scheduler searches candidates starting at that level's pointer and moving upward with wrap-around. After a grant, the pointer moves to the port just after the granted one.
- R6: A level's pointer changes only in a cycle that grants a flit of that level.
- R7: Once a head flit without tail is sent at a level, only that input may send at that level until it sends a tail flit. Other inputs' heads at that level wait.
- R8: A lower-numbered level may send while a higher-numbered level is locked mid-packet. The locked packet later resumes with the same owner input.
- R9: At an unlocked level only slots flagged as head are candidates. A non-head flit there is not sent.
- R10: Slot bit index is `port*4 + level`. `grant` has exactly the selected slot's bit set. `out_port`, `out_lvl`, `out_head`, `out_tail` and `out_data` reflect that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_vld | input | 20 | Pending-flit valid per slot, bit port*4+level |
| in_head | input | 20 | Slot's flit is a packet head |
| in_tail | input | 20 | Slot's flit is a packet tail |
| in_data | input | 320 | Flit payload per slot, slot s at [s*16 +: 16] |
| credit_ret | input | 4 | One credit returned per level |
| grant | output | 20 | One-hot pop toward the selected slot |
| out_vld | output | 1 | A flit is sent this cycle |
| out_port | output | 3 | Input port of the sent flit |
| out_lvl | output | 2 | Service level of the sent flit |
| out_head | output | 1 | Sent flit is a head |
| out_tail | output | 1 | Sent flit is a tail |
| out_data | output | 16 | Sent flit payload |
| credit_cnt | output | 12 | Credit counters, 3 bits per level |

## Verification
The hardest case to reach is a level-3 packet that is locked part-way through while other traffic cuts in. The bench first starts that packet. A rival input then presents a head at the same level, so the lock's effect shows. A single-flit signaling packet then preempts it. The tail must still come from the original owner. Credit exhaustion takes longer to reach. The stimulus table drains level 3 and level 0 to zero credits with back-to-back sends. It then returns credits in the same cycle as a send, so that the starved level and the fallback level both show at the ports.

// File: rtl/fos_pkg.sv
package fos_pkg;
    typedef enum logic [1:0] {
        SL_SIGNAL = 2'd0,
        SL_STREAM = 2'd1,
        SL_RDWR   = 2'd2,
        SL_BULK   = 2'd3
    } svc_lvl_e;
endpackage

// File: rtl/fos_credit.sv
module fos_credit #(
    parameter  int DEPTH = 4,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic          give,
    output logic [CW-1:0] count,
    output logic          avail
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (take && !give)      cnt_d = cnt_q - CW'(1);
        else if (give && !take) cnt_d = cnt_q + CW'(1);
        avail = (cnt_q != '0);
        count = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= CW'(DEPTH);
        else        cnt_q <= cnt_d;
    end

    // R4
    credit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));
    // R3
    take_with_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (cnt_q != '0));
    // R4
    credit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !give) |=> (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/fos_lvl_arb.sv
module fos_lvl_arb #(
    parameter  int NUM_IN = 5,
    localparam int IW     = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] flit_vld,
    input  logic [NUM_IN-1:0] flit_head,
    input  logic [NUM_IN-1:0] flit_tail,
    input  logic              credit_ok,
    input  logic              win,
    output logic              has_req,
    output logic [IW-1:0]     pick_idx
);
    typedef struct packed {
        logic          lock;
        logic [IW-1:0] owner;
        logic [IW-1:0] ptr;
    } arb_st_t;

    arb_st_t          st_d, st_q;
    logic [NUM_IN-1:0] cand;
    logic              found;

    always_comb begin
        for (int i = 0; i < NUM_IN; i++) begin
            if (st_q.lock) cand[i] = flit_vld[i] && (st_q.owner == IW'(i));
            else           cand[i] = flit_vld[i] && flit_head[i];
        end

        found    = 1'b0;
        pick_idx = '0;
        for (int k = 0; k < NUM_IN; k++) begin
            int t;
            t = int'(st_q.ptr) + k;
            if (t >= NUM_IN) t = t - NUM_IN;
            for (int i = 0; i < NUM_IN; i++) begin
                if (!found && (i == t) && cand[i]) begin
                    found    = 1'b1;
                    pick_idx = IW'(i);
                end
            end
        end
        has_req = found && credit_ok;

        st_d = st_q;
        if (win) begin
            st_d.ptr = (pick_idx == IW'(NUM_IN - 1)) ? '0 : pick_idx + IW'(1);
            if (flit_tail[pick_idx]) begin
                st_d.lock = 1'b0;
            end else if (flit_head[pick_idx]) begin
                st_d.lock  = 1'b1;
                st_d.owner = pick_idx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win |=> $stable(st_q.ptr));
    // R7
    lock_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win && st_q.lock) |-> (pick_idx == st_q.owner));
    // R9
    head_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win && !st_q.lock) |-> flit_head[pick_idx]);
    // R3
    win_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win |-> (credit_ok && flit_vld[pick_idx]));
endmodule

// File: rtl/flit_out_sched.sv
module flit_out_sched #(
    parameter  int NUM_IN  = 5,
    parameter  int NUM_LVL = 4,
    parameter  int DEPTH   = 4,
    parameter  int DATA_W  = 16,
    localparam int IW      = (NUM_IN > 1) ? $clog2(NUM_IN) : 1,
    localparam int LW      = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1,
    localparam int CW      = $clog2(DEPTH + 1),
    localparam int NS      = NUM_IN * NUM_LVL
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NS-1:0]        in_vld,
    input  logic [NS-1:0]        in_head,
    input  logic [NS-1:0]        in_tail,
    input  logic [NS*DATA_W-1:0] in_data,
    input  logic [NUM_LVL-1:0]   credit_ret,
    output logic [NS-1:0]        grant,
    output logic                 out_vld,
    output logic [IW-1:0]        out_port,
    output logic [LW-1:0]        out_lvl,
    output logic                 out_head,
    output logic                 out_tail,
    output logic [DATA_W-1:0]    out_data,
    output logic [NUM_LVL*CW-1:0] credit_cnt
);
    import fos_pkg::*;

    logic [NUM_IN-1:0]  lvl_vld  [NUM_LVL];
    logic [NUM_IN-1:0]  lvl_head [NUM_LVL];
    logic [NUM_IN-1:0]  lvl_tail [NUM_LVL];
    logic [IW-1:0]      lvl_pick [NUM_LVL];
    logic [CW-1:0]      lvl_cnt  [NUM_LVL];
    logic [NUM_LVL-1:0] lvl_ok;
    logic [NUM_LVL-1:0] lvl_req;
    logic [NUM_LVL-1:0] lvl_win;
    logic [NUM_LVL-1:0] lvl_take;

    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        for (genvar i = 0; i < NUM_IN; i++) begin : g_in
            assign lvl_vld[l][i]  = in_vld[i*NUM_LVL + l];
            assign lvl_head[l][i] = in_head[i*NUM_LVL + l];
            assign lvl_tail[l][i] = in_tail[i*NUM_LVL + l];
        end

        fos_credit #(.DEPTH(DEPTH)) u_credit (
            .clk   (clk),
            .rst_n (rst_n),
            .take  (lvl_take[l]),
            .give  (credit_ret[l]),
            .count (lvl_cnt[l]),
            .avail (lvl_ok[l])
        );

        fos_lvl_arb #(.NUM_IN(NUM_IN)) u_arb (
            .clk       (clk),
            .rst_n     (rst_n),
            .flit_vld  (lvl_vld[l]),
            .flit_head (lvl_head[l]),
            .flit_tail (lvl_tail[l]),
            .credit_ok (lvl_ok[l]),
            .win       (lvl_win[l]),
            .has_req   (lvl_req[l]),
            .pick_idx  (lvl_pick[l])
        );

        assign credit_cnt[l*CW +: CW] = lvl_cnt[l];
    end

    svc_lvl_e      sel_name;
    logic [LW-1:0] sel;
    logic          any;

    always_comb begin
        any = 1'b0;
        sel = '0;
        for (int l = 0; l < NUM_LVL; l++) begin
            if (!any && lvl_req[l]) begin
                any = 1'b1;
                sel = LW'(l);
            end
        end
        sel_name = svc_lvl_e'(sel[1:0]);

        for (int l = 0; l < NUM_LVL; l++) begin
            lvl_win[l]  = any && (sel == LW'(l));
            lvl_take[l] = lvl_win[l];
        end

        out_vld  = any;
        out_lvl  = sel;
        out_port = lvl_pick[sel];
        grant    = '0;
        out_head = 1'b0;
        out_tail = 1'b0;
        out_data = '0;
        for (int i = 0; i < NUM_IN; i++) begin
            for (int l = 0; l < NUM_LVL; l++) begin
                if (any && (out_port == IW'(i)) && (sel == LW'(l))) begin
                    grant[i*NUM_LVL + l] = 1'b1;
                    out_head = in_head[i*NUM_LVL + l];
                    out_tail = in_tail[i*NUM_LVL + l];
                    out_data = in_data[(i*NUM_LVL + l)*DATA_W +: DATA_W];
                end
            end
        end
    end

    // R10
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && (out_vld == (grant != '0)));
    // R10
    grant_is_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant & ~in_vld) == '0));
    // R2
    signal_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_req[0] && out_vld) |-> (sel_name == SL_SIGNAL));
    // R1
    idle_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_vld && (credit_ret == '0)) |=> $stable(credit_cnt));
endmodule

// File: tb/flit_out_sched_bench.sv
module flit_out_sched_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [19:0]  in_vld = '0, in_head = '0, in_tail = '0;
    logic [319:0] in_data;
    logic [3:0]   credit_ret = '0;
    logic [19:0]  grant;
    logic         out_vld, out_head, out_tail;
    logic [2:0]   out_port;
    logic [1:0]   out_lvl;
    logic [15:0]  out_data;
    logic [11:0]  credit_cnt;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    flit_out_sched u_flit_out_sched (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_head(in_head),
        .in_tail(in_tail), .in_data(in_data), .credit_ret(credit_ret),
        .grant(grant), .out_vld(out_vld), .out_port(out_port),
        .out_lvl(out_lvl), .out_head(out_head), .out_tail(out_tail),
        .out_data(out_data), .credit_cnt(credit_cnt)
    );

    typedef struct packed {
        logic [19:0] vld;
        logic [19:0] head;
        logic [19:0] tail;
        logic [3:0]  cret;
        logic        ev;
        logic [2:0]  ep;
        logic [1:0]  el;
    } row_t;

    localparam int NROW = 16;
    localparam row_t TBL [NROW] = '{
        '{20'h00000, 20'h00000, 20'h00000, 4'h0, 1'b0, 3'd0, 2'd0}, // R1 idle
        '{20'h00208, 20'h00208, 20'h00200, 4'h0, 1'b1, 3'd2, 2'd1}, // R2
        '{20'h00008, 20'h00008, 20'h00000, 4'h0, 1'b1, 3'd0, 2'd3}, // R7 opens lock
        '{20'h00088, 20'h00080, 20'h00000, 4'h0, 1'b1, 3'd0, 2'd3}, // R7 rival waits
        '{20'h10088, 20'h10080, 20'h10000, 4'h0, 1'b1, 3'd4, 2'd0}, // R8 preempt
        '{20'h00088, 20'h00080, 20'h00008, 4'h0, 1'b1, 3'd0, 2'd3}, // R8 resume
        '{20'h00080, 20'h00080, 20'h00080, 4'h8, 1'b1, 3'd1, 2'd3}, // R5
        '{20'h08080, 20'h08080, 20'h08080, 4'h0, 1'b1, 3'd3, 2'd3}, // R5 pointer
        '{20'h00080, 20'h00080, 20'h00080, 4'h0, 1'b0, 3'd0, 2'd0}, // R3 no credit
        '{20'h00080, 20'h00080, 20'h00080, 4'h8, 1'b0, 3'd0, 2'd0}, // R3 return
        '{20'h00080, 20'h00080, 20'h00080, 4'h0, 1'b1, 3'd1, 2'd3}, // R6 pointer held
        '{20'h00001, 20'h00001, 20'h00001, 4'h0, 1'b1, 3'd0, 2'd0},
        '{20'h00001, 20'h00001, 20'h00001, 4'h0, 1'b1, 3'd0, 2'd0},
        '{20'h00001, 20'h00001, 20'h00001, 4'h0, 1'b1, 3'd0, 2'd0},
        '{20'h00005, 20'h00005, 20'h00005, 4'h0, 1'b1, 3'd0, 2'd2}, // R3 fallback
        '{20'h02000, 20'h00000, 20'h00000, 4'h0, 1'b0, 3'd0, 2'd0}  // R9
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #1000000;
        chk(1'b0, "WDOG", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        for (int s = 0; s < 20; s++) in_data[s*16 +: 16] = 16'hC000 | 16'(s);
        repeat (3) @(negedge clk);
        chk(credit_cnt == 12'h924, "R4", "credit reset", credit_cnt, 12'h924);
        chk(out_vld == 1'b0 && grant == '0, "R1", "reset idle", out_vld, 0);
        rst_n = 1'b1;

        for (int r = 0; r < NROW; r++) begin
            @(negedge clk);
            in_vld = TBL[r].vld; in_head = TBL[r].head;
            in_tail = TBL[r].tail; credit_ret = TBL[r].cret;
            #2;
            chk(out_vld == TBL[r].ev, "R1/R2/R3", $sformatf("row %0d out_vld", r),
                out_vld, TBL[r].ev);
            if (TBL[r].ev) begin
                chk(out_port == TBL[r].ep && out_lvl == TBL[r].el, "R2/R5/R7/R8",
                    $sformatf("row %0d port,lvl", r),
                    {out_port, out_lvl}, {TBL[r].ep, TBL[r].el});
                chk(grant == (20'd1 << (TBL[r].ep * 4 + TBL[r].el)), "R10",
                    $sformatf("row %0d grant", r), grant,
                    20'd1 << (TBL[r].ep * 4 + TBL[r].el));
                chk(out_data == (16'hC000 | 16'(TBL[r].ep * 4 + TBL[r].el)), "R10",
                    $sformatf("row %0d data", r), out_data,
                    16'hC000 | 16'(TBL[r].ep * 4 + TBL[r].el));
            end else begin
                chk(grant == '0, "R1", $sformatf("row %0d grant idle", r), grant, 0);
            end
        end

        @(negedge clk);
        in_vld = '0; in_head = '0; in_tail = '0; credit_ret = '0;
        #2;
        // R4 after table: l0=0, l1=3, l2=3, l3=0
        chk(credit_cnt == 12'h0D8, "R4", "credits after table", credit_cnt, 12'h0D8);

        // R3/R4: level 0 starved, a return arrives, nothing sent this cycle
        @(negedge clk);
        in_vld = 20'h00001; in_head = 20'h00001; in_tail = 20'h00001;
        credit_ret = 4'h1;
        #2;
        chk(out_vld == 1'b0, "R3", "starved level 0 idle", out_vld, 0);
        @(negedge clk);
        credit_ret = 4'h1;
        #2;
        chk(out_vld && out_lvl == 2'd0, "R3", "level 0 after return", out_lvl, 0);
        @(negedge clk);
        in_vld = '0; in_head = '0; in_tail = '0; credit_ret = '0;
        #2;
        // R4 send and return in one cycle leaves level 0 at 1
        chk(credit_cnt[2:0] == 3'd1, "R4", "same-cycle send and return",
            credit_cnt[2:0], 1);

        // R9 body flit at unlocked level 1 stays unsent; credit unchanged
        @(negedge clk);
        in_vld = 20'h00020; in_head = '0; in_tail = 20'h00020;
        #2;
        chk(out_vld == 1'b0, "R9", "non-head at unlocked level", out_vld, 0);
        @(negedge clk);
        in_vld = '0; in_tail = '0;
        #2;
        chk(credit_cnt[5:3] == 3'd3, "R1", "idle keeps credit", credit_cnt[5:3], 3);

        finish_run();
    end
endmodule